// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single synchronous decade that holds one binary-coded decimal digit (0 to 9) and steps it up or down on the rising clock edge. A direction input selects the sense of the count, and an active-low enable gates stepping. When the enable is high the digit holds. An active-high master clear and an active-high parallel load both act without waiting for a clock, and the clear wins over the load. While load is high the outputs show the four data inputs, and the value present when load falls stays in the counter.

An active-low terminal-count output marks the last state in the current direction while the decade is enabled: 9 (or any code with bits 0 and 3 set) counting up, 0 counting down. Decades are chained by feeding this output to the next stage's enable. Codes 10 to 15 can only enter through the parallel load. The next count returns them to the BCD range: to 0 when counting up, to 9 when counting down.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `mr` is 1 the output `q` is 0000 without waiting for a clock, whatever `pl`, `ce_n`, `up` and `d` are. After `mr` falls, counting starts from 0.
- R2: While `pl` is 1 and `mr` is 0, `q` equals `d` without waiting for a clock, whatever `ce_n` and `up` are.
- R3: After `pl` falls, the counter keeps the value that was on `d` and counts on from it.
- R4: With `mr` and `pl` at 0 and `ce_n` at 1, `q` does not change across clock edges, in either direction.
- R5: With `ce_n` at 0 and `up` at 1, each rising edge adds one to a legal code, and 9 wraps to 0.
- R6: With `ce_n` at 0 and `up` at 0, each rising edge subtracts one from a legal code, and 0 wraps to 9.
- R7: With `up` at 1, `tc_n` is 0 exactly when `ce_n` is 0 and bits q[0] and q[3] are both 1. Otherwise it is 1. Bit q[0] is the least significant.
- R8: With `up` at 0, `tc_n` is 0 exactly when `ce_n` is 0 and `q` is 0000. Otherwise it is 1.
- R9: Counting up from any code 10 to 15 gives 0 after one rising edge.
- R10: Counting down from any code 10 to 15 gives 9 after one rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge |
| mr | input | 1 | Master clear, active high, asynchronous, highest priority |
| pl | input | 1 | Parallel load, active high, asynchronous |
| ce_n | input | 1 | Count enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| d | input | 4 | Parallel data, d[0] least significant |
| q | output | 4 | Current digit, q[0] least significant |
| tc_n | output | 1 | Terminal count, active low, includes the enable |

## Verification
The counter is driven through long runs of up counts and down counts that cross each wrap point, with the enable held high in both directions. These runs separate stepping, holding and the two terminal-count decodes. Clear and load are raised mid-cycle against conflicting enable and direction values and sampled before the next edge, which shows that they act without a clock and in the right order of priority. Every code from 10 to 15 is loaded and then stepped once up and once down, which separates the two recovery paths. It also exercises the up decode at 11, 13 and 15.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
    localparam int DIGIT_W  = 4;
    localparam int TOP_CODE = 9;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_cnt_pkg::*;
#(
    parameter int W   = DIGIT_W,
    parameter int TOP = TOP_CODE
) (
    input  logic [W-1:0] cur,
    input  logic         dir_up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP_V  = W'(TOP);
    localparam logic [W-1:0] ZERO_V = '0;
    localparam logic [W-1:0] ONE_V  = W'(1);

    always_comb begin
        if (dir_e'(dir_up) == DIR_UP) begin
            // last legal code and every illegal code fold to zero
            if (cur >= TOP_V) nxt = ZERO_V;
            else              nxt = cur + ONE_V;
        end else begin
            // zero and every illegal code fold to the top code
            if (cur == ZERO_V || cur > TOP_V) nxt = TOP_V;
            else                              nxt = cur - ONE_V;
        end
    end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
    import bcd_cnt_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic [W-1:0] q_i,
    input  logic         dir_up,
    input  logic         ce_n,
    output logic         tc_n
);
    logic hit_up;
    logic hit_dn;

    always_comb begin
        hit_up = q_i[0] & q_i[W-1];
        hit_dn = (q_i == '0);
        if (ce_n) tc_n = 1'b1;
        else if (dir_e'(dir_up) == DIR_UP) tc_n = ~hit_up;
        else tc_n = ~hit_dn;
    end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_cnt_pkg::*;
#(
    parameter int W   = DIGIT_W,
    parameter int TOP = TOP_CODE
) (
    input  logic         clk,
    input  logic         mr,
    input  logic         pl,
    input  logic         ce_n,
    input  logic         up,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tc_n
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t   st_d;
    cnt_state_t   st_q;
    logic [W-1:0] step_d;

    bcd_step #(.W(W), .TOP(TOP)) u_step (
        .cur    (st_q.cnt),
        .dir_up (up),
        .nxt    (step_d)
    );

    // next value for a clock edge with clear and load both low
    always_comb begin
        st_d = st_q;
        if (!ce_n) st_d.cnt = step_d;
    end

    // clear and load act on their own edges; on a clock edge they still dominate
    always_ff @(posedge clk or posedge mr or posedge pl) begin
        if (mr)      st_q.cnt <= '0;
        else if (pl) st_q.cnt <= d;
        else         st_q     <= st_d;
    end

    // outputs follow clear and load transparently, without a clock
    always_comb begin
        if (mr)      q = '0;
        else if (pl) q = d;
        else         q = st_q.cnt;
    end

    bcd_tc_decode #(.W(W)) u_tc (
        .q_i    (q),
        .dir_up (up),
        .ce_n   (ce_n),
        .tc_n   (tc_n)
    );

    // R4: enable high holds the digit
    p_hold_r4: assert property (@(posedge clk) disable iff (mr)
        (ce_n && !pl) |=> (pl || $stable(q)))
        else $error("p_hold_r4");

    // R5: legal up step adds one
    p_inc_r5: assert property (@(posedge clk) disable iff (mr)
        (!ce_n && !pl && up && q < TOP_V) |=> (pl || q == $past(q) + W'(1)))
        else $error("p_inc_r5");

    // R6: legal down step subtracts one
    p_dec_r6: assert property (@(posedge clk) disable iff (mr)
        (!ce_n && !pl && !up && q != '0 && q <= TOP_V) |=> (pl || q == $past(q) - W'(1)))
        else $error("p_dec_r6");

    // R5, R9: top and illegal codes go to zero counting up
    p_upwrap_r9: assert property (@(posedge clk) disable iff (mr)
        (!ce_n && !pl && up && q >= TOP_V) |=> (pl || q == '0))
        else $error("p_upwrap_r9");

    // R6, R10: zero and illegal codes go to the top code counting down
    p_dnwrap_r10: assert property (@(posedge clk) disable iff (mr)
        (!ce_n && !pl && !up && (q == '0 || q > TOP_V)) |=> (pl || q == TOP_V))
        else $error("p_dnwrap_r10");

    // R7, R8: terminal count only while enabled
    p_tc_enable_r7: assert property (@(posedge clk) disable iff (mr)
        !tc_n |-> !ce_n)
        else $error("p_tc_enable_r7");
endmodule

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb_top;
    localparam int HALF = 4;  // 125 MHz

    logic       clk = 1'b0;
    logic       mr  = 1'b1;
    logic       pl  = 1'b0;
    logic       ce_n = 1'b1;
    logic       up  = 1'b1;
    logic [3:0] d   = 4'd0;
    logic [3:0] q;
    logic       tc_n;

    int errors = 0;
    int checks = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #HALF clk = ~clk;

    bcd_decade_counter dut_i (
        .clk(clk), .mr(mr), .pl(pl), .ce_n(ce_n), .up(up),
        .d(d), .q(q), .tc_n(tc_n)
    );

    function automatic int exp_q();
        if (mr) return 0;
        if (pl) return int'(d);
        return model;
    endfunction

    function automatic logic exp_tc(input int v);
        if (ce_n) return 1'b1;
        if (up) return !(((v % 2) == 1) && (v >= 8));
        return !(v == 0);
    endfunction

    task automatic check(input string tag);
        int ev;
        ev = exp_q();
        checks++;
        if (q !== 4'(ev)) begin
            errors++;
            $display("FAIL %s q actual=%0d expected=%0d", tag, q, ev);
        end
        checks++;
        if (tc_n !== exp_tc(ev)) begin
            errors++;
            $display("FAIL %s tc_n actual=%0b expected=%0b (q=%0d up=%0b ce_n=%0b)",
                     up ? "R7" : "R8", tc_n, exp_tc(ev), ev, up, ce_n);
        end
    endtask

    // apply inputs just after a falling edge, check, then model the next rising edge
    task automatic cyc(input logic m, input logic l, input logic c, input logic u,
                       input logic [3:0] dv, input string tag);
        @(negedge clk);
        d = dv; mr = m; pl = l; ce_n = c; up = u;
        if (mr) model = 0;
        else if (pl) model = int'(d);
        #1;
        check(tag);
        @(posedge clk);
        if (mr) model = 0;
        else if (pl) model = int'(d);
        else if (!ce_n) begin
            if (up) model = (model >= 9) ? 0 : model + 1;
            else    model = (model == 0 || model > 9) ? 9 : model - 1;
        end
    endtask

    initial begin
        // R1: clear overrides load and count
        cyc(1, 1, 0, 1, 4'd5, "R1");
        cyc(1, 1, 0, 0, 4'd7, "R1");
        cyc(1, 0, 0, 1, 4'd2, "R1");
        // R1: counting restarts from zero
        cyc(0, 0, 0, 1, 4'd0, "R1");
        cyc(0, 0, 0, 1, 4'd0, "R5");
        // R2: load shows d without a clock, any enable or direction
        cyc(0, 1, 1, 0, 4'd7, "R2");
        cyc(0, 1, 0, 1, 4'd3, "R2");
        // R3: value retained after load falls, counting resumes
        cyc(0, 0, 1, 1, 4'd0, "R3");
        cyc(0, 0, 0, 1, 4'd0, "R3");
        // R5, R7: up count across the wrap
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 1, 4'd0, "R5");
        // R4: hold with enable high, both directions
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 4'd0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 4'd0, "R4");
        // R6, R8: down count across the wrap
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 4'd0, "R6");
        // R7, R8: tc with enable toggled at the terminal states
        cyc(0, 1, 0, 1, 4'd9, "R7");
        cyc(0, 0, 1, 1, 4'd0, "R7");
        cyc(0, 0, 0, 1, 4'd0, "R7");
        cyc(0, 1, 0, 0, 4'd0, "R8");
        cyc(0, 0, 1, 0, 4'd0, "R8");
        cyc(0, 0, 0, 0, 4'd0, "R8");
        // R9, R10: recovery from every illegal code
        for (int code = 10; code < 16; code++) begin
            cyc(0, 1, 0, 1, 4'(code), "R2");
            cyc(0, 0, 0, 1, 4'd0, "R9");
            cyc(0, 0, 1, 1, 4'd0, "R9");
            cyc(0, 1, 1, 0, 4'(code), "R2");
            cyc(0, 0, 0, 0, 4'd0, "R10");
            cyc(0, 0, 1, 0, 4'd0, "R10");
        end
        // R1: clear in the middle of counting
        cyc(0, 0, 0, 1, 4'd0, "R5");
        cyc(1, 0, 0, 1, 4'd0, "R1");
        cyc(0, 0, 1, 1, 4'd0, "R1");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(2 * HALF * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule